// File: doc/BRIEF.md
# Indirect CSR Window Access Checker

This block gives a hart with hypervisor support an indirect register window. It holds a 12-bit select register for the virtual-supervisor level and a small bank of target registers behind it. A CSR access names the select register, the virtual-supervisor data window or the supervisor data window, and carries the current privilege mode. The supervisor window, when used from the virtualized mode, is redirected onto the virtual-supervisor window and uses the same select value.

Each request either completes or raises exactly one trap, illegal-instruction or virtual-instruction. The choice depends on three things together: what the select value resolves to (an implemented target, a reserved value, or an implemented target that is masked off), the privilege mode, and which window was addressed. A target's own permission check (here, a read-only flag) runs only after the select value has resolved to an accessible target. Results appear one cycle after the request is accepted, with the faulting instruction bits carried alongside the trap.

Top module: `ind_csr_window`

## Requirements
- R1: After reset the select register holds 0, target i holds the value i, `trap_kind` is 3'b001 and `rsp_valid` is low.
- R2: The select register (`req_csr` 2'b00) can be read and written from M (`req_priv` 2'b00), HS (2'b01) and VS (2'b10); a write keeps only `req_wdata[11:0]`, and a read returns the value zero-extended.
- R3: Select values 0x030 to 0x033 name targets 0 to 3 and 0x200 to 0x201 (inside the custom range 0x200 to 0x2FF) name targets 4 and 5; every other value is reserved, and a window access through it raises illegal-instruction from any mode.
- R4: A VS-window access (`req_csr` 2'b01) from M or HS to an accessible target completes: a write stores `req_wdata` at the accept edge, a read returns the target value one cycle later with `rsp_valid` high.
- R5: A supervisor-window access (`req_csr` 2'b10) from VS reaches the same target, chosen by the same select value, as the VS window does from M or HS.
- R6: A target whose `acc_mask` bit is clear is inaccessible: reaching it via the VS window from M or HS raises illegal-instruction, via the supervisor window from VS raises virtual-instruction.
- R7: The VS window used from VS raises virtual-instruction; the supervisor window used from M or HS raises illegal-instruction.
- R8: Target 2 is read-only: a write that resolves to it raises illegal-instruction from any mode, a read completes; an inaccessible target traps per R6 before this check.
- R9: A request that traps changes neither the select register nor any target.
- R10: `trap_kind` is one-hot, bit 0 none, bit 1 illegal, bit 2 virtual; it reports the request accepted on the previous edge (none when there was none), and `trap_insn` equals that request's `req_insn` when it trapped and zero otherwise.
- R11: `rsp_valid` is high only for a completed read; whenever it is low, `rsp_rdata` is zero (trapping reads and writes included).
- R12: A privilege code of 2'b11 or a CSR code of 2'b11 raises illegal-instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request accepted at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 2 | Privilege mode: 00 M, 01 HS, 10 VS, 11 invalid |
| req_csr | input | 2 | 00 select, 01 VS window, 10 supervisor window, 11 invalid |
| req_wdata | input | 32 | Write data |
| req_insn | input | 32 | Instruction bits of the request |
| acc_mask | input | 6 | Per-target accessibility, bit i for target i |
| rsp_valid | output | 1 | Completed read data valid |
| rsp_rdata | output | 32 | Read data, zero unless valid |
| trap_kind | output | 3 | One-hot trap: bit0 none, bit1 illegal, bit2 virtual |
| trap_insn | output | 32 | Instruction bits of the trapping request |

## Verification
The assertions assume that `req_priv`, `req_csr`, `req_write` and `acc_mask` are known and steady across the edge at which a request is accepted, since the trap decision samples them there together. The stimulus changes every input only at the falling clock edge, holds `acc_mask` with its request, and weights random select values toward the implemented and boundary numbers so that reserved, masked, read-only and successful outcomes all occur in every mode.

// File: rtl/ind_csr_pkg.sv
package ind_csr_pkg;

    localparam int SEL_W = 12;
    localparam logic [SEL_W-1:0] CUSTOM_LO = 12'h200;
    localparam logic [SEL_W-1:0] CUSTOM_HI = 12'h2FF;

    typedef enum logic [1:0] {
        PRIV_M   = 2'b00,
        PRIV_HS  = 2'b01,
        PRIV_VS  = 2'b10,
        PRIV_BAD = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        CSR_SELECT = 2'b00,
        CSR_VSWIN  = 2'b01,
        CSR_SWIN   = 2'b10,
        CSR_BAD    = 2'b11
    } csr_e;

    typedef struct packed {
        logic virt;
        logic illegal;
        logic none;
    } trap_t;

    localparam trap_t TRAP_NONE    = '{virt: 1'b0, illegal: 1'b0, none: 1'b1};
    localparam trap_t TRAP_ILLEGAL = '{virt: 1'b0, illegal: 1'b1, none: 1'b0};
    localparam trap_t TRAP_VIRTUAL = '{virt: 1'b1, illegal: 1'b0, none: 1'b0};

    function automatic logic in_custom(input logic [SEL_W-1:0] s);
        return (s >= CUSTOM_LO) && (s <= CUSTOM_HI);
    endfunction

endpackage

// File: rtl/ind_sel_decode.sv
module ind_sel_decode
    import ind_csr_pkg::*;
#(
    parameter int NUM_STD  = 4,
    parameter int STD_BASE = 'h030,
    parameter int NUM_CUS  = 2,
    localparam int NT      = NUM_STD + NUM_CUS,
    localparam int IDX_W   = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic [SEL_W-1:0] sel,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < NUM_STD; i++) begin
            if (sel == SEL_W'(STD_BASE + i)) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
        if (in_custom(sel)) begin
            for (int j = 0; j < NUM_CUS; j++) begin
                if (sel == CUSTOM_LO + SEL_W'(j)) begin
                    hit = 1'b1;
                    idx = IDX_W'(NUM_STD + j);
                end
            end
        end
    end
endmodule

// File: rtl/ind_access_ctl.sv
module ind_access_ctl
    import ind_csr_pkg::*;
(
    input  logic [1:0] priv,
    input  logic [1:0] csr,
    input  logic       write,
    input  logic       hit,
    input  logic       accessible,
    input  logic       read_only,
    output trap_t      trap,
    output logic       win_ok
);
    logic is_vs;
    logic resolve;

    assign is_vs = (priv == PRIV_VS);

    always_comb begin
        trap    = TRAP_NONE;
        resolve = 1'b0;
        if (priv == PRIV_BAD || csr == CSR_BAD) begin
            trap = TRAP_ILLEGAL;
        end else begin
            unique case (csr)
                CSR_SELECT: trap = TRAP_NONE;
                CSR_VSWIN: begin
                    if (is_vs) trap = TRAP_VIRTUAL;
                    else       resolve = 1'b1;
                end
                CSR_SWIN: begin
                    if (is_vs) resolve = 1'b1;
                    else       trap = TRAP_ILLEGAL;
                end
                default: trap = TRAP_ILLEGAL;
            endcase
        end
        if (resolve) begin
            if (!hit)                    trap = TRAP_ILLEGAL;
            else if (!accessible)        trap = is_vs ? TRAP_VIRTUAL : TRAP_ILLEGAL;
            else if (write && read_only) trap = TRAP_ILLEGAL;
        end
        win_ok = resolve && trap.none;
    end
endmodule

// File: rtl/ind_target_bank.sv
module ind_target_bank #(
    parameter int          NT      = 6,
    parameter int          XLEN    = 32,
    parameter logic [NT-1:0] RO_MASK = 6'b000100,
    localparam int         IDX_W   = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [XLEN-1:0]  wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [XLEN-1:0]  rdata
);
    logic [XLEN-1:0] store [NT];

    for (genvar i = 0; i < NT; i++) begin : g_tgt
        if (RO_MASK[i]) begin : g_ro
            assign store[i] = XLEN'(i);
        end else begin : g_rw
            logic [XLEN-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)                                  q <= XLEN'(i);
                else if (we && widx == IDX_W'(i))         q <= wdata;
            end
            assign store[i] = q;
        end
    end

    assign rdata = (int'(ridx) < NT) ? store[ridx] : '0;

    assert_ro_never_written_R8: assert property (@(posedge clk) disable iff (rst)
        we |-> !RO_MASK[widx]);
endmodule

// File: rtl/ind_csr_window.sv
module ind_csr_window
    import ind_csr_pkg::*;
#(
    parameter int            XLEN     = 32,
    parameter int            NUM_STD  = 4,
    parameter int            STD_BASE = 'h030,
    parameter int            NUM_CUS  = 2,
    parameter logic [5:0]    RO_MASK  = 6'b000100,
    localparam int           NT       = NUM_STD + NUM_CUS,
    localparam int           IDX_W    = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [1:0]      req_priv,
    input  logic [1:0]      req_csr,
    input  logic [XLEN-1:0] req_wdata,
    input  logic [XLEN-1:0] req_insn,
    input  logic [NT-1:0]   acc_mask,
    output logic            rsp_valid,
    output logic [XLEN-1:0] rsp_rdata,
    output logic [2:0]      trap_kind,
    output logic [XLEN-1:0] trap_insn
);
    logic [SEL_W-1:0] sel_q;
    logic             hit;
    logic [IDX_W-1:0] idx;
    trap_t            trap;
    logic             win_ok;
    logic             sel_we;
    logic             bank_we;
    logic [XLEN-1:0]  bank_rdata;
    logic [XLEN-1:0]  rd_next;
    logic             ok;
    trap_t            trap_q;

    ind_sel_decode #(.NUM_STD(NUM_STD), .STD_BASE(STD_BASE), .NUM_CUS(NUM_CUS)) u_dec (
        .sel(sel_q), .hit(hit), .idx(idx)
    );

    ind_access_ctl u_ctl (
        .priv(req_priv), .csr(req_csr), .write(req_write),
        .hit(hit), .accessible(acc_mask[idx]), .read_only(RO_MASK[idx]),
        .trap(trap), .win_ok(win_ok)
    );

    assign ok      = req_valid && trap.none;
    assign sel_we  = ok && req_write && (req_csr == CSR_SELECT);
    assign bank_we = ok && req_write && win_ok;

    ind_target_bank #(.NT(NT), .XLEN(XLEN), .RO_MASK(RO_MASK)) u_bank (
        .clk(clk), .rst(rst), .we(bank_we), .widx(idx), .wdata(req_wdata),
        .ridx(idx), .rdata(bank_rdata)
    );

    assign rd_next = (req_csr == CSR_SELECT) ? XLEN'(sel_q) : bank_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            trap_q    <= TRAP_NONE;
            trap_insn <= '0;
        end else begin
            if (sel_we) sel_q <= req_wdata[SEL_W-1:0];
            rsp_valid <= ok && !req_write;
            rsp_rdata <= (ok && !req_write) ? rd_next : '0;
            trap_q    <= req_valid ? trap : TRAP_NONE;
            trap_insn <= (req_valid && !trap.none) ? req_insn : '0;
        end
    end

    assign trap_kind = trap_q;

    assert_trap_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot(trap_kind));

    assert_rdata_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> rsp_rdata == '0);

    assert_valid_no_trap_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> trap_kind == 3'b001);

    assert_trap_keeps_sel_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !trap.none) |=> $stable(sel_q));

    assert_vs_window_in_vs_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_priv == PRIV_VS && req_csr == CSR_VSWIN) |=> trap_kind == 3'b100);

    assert_reserved_illegal_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !hit &&
         ((req_csr == CSR_VSWIN && (req_priv == PRIV_M || req_priv == PRIV_HS)) ||
          (req_csr == CSR_SWIN && req_priv == PRIV_VS))) |=> trap_kind == 3'b010);

    assert_bad_code_R12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_priv == PRIV_BAD || req_csr == CSR_BAD)) |=> trap_kind == 3'b010);
endmodule

// File: tb/sim_ind_csr_window.sv
module sim_ind_csr_window;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [1:0]  req_priv, req_csr;
    logic [31:0] req_wdata, req_insn;
    logic [5:0]  acc_mask;
    logic        rsp_valid;
    logic [31:0] rsp_rdata, trap_insn;
    logic [2:0]  trap_kind;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [11:0] m_sel;
    logic [31:0] m_tgt [6];

    always #4 clk = ~clk;

    ind_csr_window u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_priv(req_priv), .req_csr(req_csr), .req_wdata(req_wdata),
        .req_insn(req_insn), .acc_mask(acc_mask), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .trap_kind(trap_kind), .trap_insn(trap_insn)
    );

    function automatic int idx_of(input logic [11:0] s);
        if (s >= 12'h030 && s <= 12'h033) return int'(s - 12'h030);
        if (s >= 12'h200 && s <= 12'h201) return 4 + int'(s - 12'h200);
        return -1;
    endfunction

    function automatic logic [2:0] exp_trap(input logic wr, input logic [1:0] pv,
                                            input logic [1:0] cs, input logic [5:0] mk);
        int i;
        if (pv == 2'b11 || cs == 2'b11) return 3'b010;
        if (cs == 2'b00) return 3'b001;
        if (cs == 2'b01 && pv == 2'b10) return 3'b100;
        if (cs == 2'b10 && pv != 2'b10) return 3'b010;
        i = idx_of(m_sel);
        if (i < 0) return 3'b010;
        if (!mk[i]) return (pv == 2'b10) ? 3'b100 : 3'b010;
        if (wr && i == 2) return 3'b010;
        return 3'b001;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [99:0] act, input logic [99:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic req(input logic wr, input logic [1:0] pv, input logic [1:0] cs,
                       input logic [31:0] wd, input logic [5:0] mk, input string tag);
        logic [2:0]  et;
        logic        ev;
        logic [31:0] ed, ei, ins;
        int i;
        ins = $urandom;
        et  = exp_trap(wr, pv, cs, mk);
        i   = idx_of(m_sel);
        ev  = (et == 3'b001) && !wr;
        ed  = 32'h0;
        if (ev) ed = (cs == 2'b00) ? {20'h0, m_sel} : m_tgt[i];
        ei  = (et == 3'b001) ? 32'h0 : ins;
        if (et == 3'b001 && wr) begin
            if (cs == 2'b00) m_sel = wd[11:0];
            else if (i != 2) m_tgt[i] = wd;
        end
        req_valid = 1'b1; req_write = wr; req_priv = pv; req_csr = cs;
        req_wdata = wd; req_insn = ins; acc_mask = mk;
        @(negedge clk);
        req_valid = 1'b0;
        check({trap_kind, rsp_valid, rsp_rdata, trap_insn} == {et, ev, ed, ei}, tag,
              100'({trap_kind, rsp_valid, rsp_rdata, trap_insn}), 100'({et, ev, ed, ei}));
    endtask

    function automatic logic [31:0] pick_sel();
        case ($urandom_range(0, 7))
            0: return 32'h030 + 32'($urandom_range(0, 3));
            1: return 32'h200 + 32'($urandom_range(0, 1));
            2: return 32'h032;
            3: return 32'h1FF;
            4: return 32'h202 + 32'($urandom_range(0, 253));
            5: return 32'h034;
            6: return 32'h02F;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_priv = 2'b00;
        req_csr = 2'b00; req_wdata = '0; req_insn = '0; acc_mask = 6'h3F;
        m_sel = 12'h0;
        for (int i = 0; i < 6; i++) m_tgt[i] = 32'(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check({trap_kind, rsp_valid, rsp_rdata, trap_insn} == {3'b001, 1'b0, 64'h0},
              "R1 reset outputs", 100'({trap_kind, rsp_valid}), 100'(4'b0010));
        req(0, 2'b00, 2'b00, 0, 6'h3F, "R1 R2 select reads zero");
        req(0, 2'b00, 2'b01, 0, 6'h3F, "R3 reserved select 0 illegal");
        req(1, 2'b01, 2'b00, 32'hFFFF_F030, 6'h3F, "R2 select write masked");
        req(0, 2'b10, 2'b00, 0, 6'h3F, "R2 select read from VS");
        req(0, 2'b00, 2'b01, 0, 6'h3F, "R1 R4 target0 reset value");
        req(1, 2'b01, 2'b01, 32'hDEAD_BEEF, 6'h3F, "R4 write from HS");
        req(0, 2'b00, 2'b01, 0, 6'h3F, "R4 readback");
        req(0, 2'b10, 2'b10, 0, 6'h3F, "R5 VS redirect read");
        req(0, 2'b10, 2'b01, 0, 6'h3F, "R7 VS window from VS virtual");
        req(0, 2'b00, 2'b10, 0, 6'h3F, "R7 S window from M illegal");
        req(0, 2'b01, 2'b01, 0, 6'h3E, "R6 masked from HS illegal");
        req(1, 2'b10, 2'b10, 32'h1234, 6'h3E, "R6 masked from VS virtual");
        req(0, 2'b00, 2'b01, 0, 6'h3F, "R9 target unchanged after trap");
        req(1, 2'b00, 2'b00, 32'h201, 6'h3F, "R2 select custom");
        req(1, 2'b10, 2'b10, 32'hCAFE_0005, 6'h3F, "R5 custom write from VS");
        req(0, 2'b01, 2'b01, 0, 6'h3F, "R3 R5 custom readback");
        req(1, 2'b00, 2'b00, 32'h032, 6'h3F, "R2 select ro target");
        req(1, 2'b00, 2'b01, 32'h55, 6'h3F, "R8 ro write M illegal");
        req(1, 2'b10, 2'b10, 32'h55, 6'h3F, "R8 ro write VS illegal");
        req(1, 2'b10, 2'b10, 32'h55, 6'h3B, "R8 R6 masked ro VS virtual");
        req(0, 2'b10, 2'b10, 0, 6'h3F, "R8 ro read completes");
        req(1, 2'b11, 2'b00, 32'h030, 6'h3F, "R12 bad priv illegal");
        req(1, 2'b00, 2'b11, 32'h030, 6'h3F, "R12 bad csr illegal");
        req(0, 2'b00, 2'b00, 0, 6'h3F, "R9 select unchanged after trap");
        req(1, 2'b00, 2'b00, 32'h1FF, 6'h3F, "R2 select 1FF");
        req(0, 2'b00, 2'b01, 0, 6'h3F, "R3 1FF reserved");
        req(1, 2'b00, 2'b00, 32'h202, 6'h3F, "R2 select 202");
        req(0, 2'b10, 2'b10, 0, 6'h3F, "R3 202 reserved from VS");
        req(1, 2'b00, 2'b00, 32'hFFF, 6'h3F, "R2 select FFF");
        req(0, 2'b00, 2'b00, 0, 6'h3F, "R2 select FFF read");
        for (int n = 0; n < 600; n++) begin
            logic [1:0] pv, cs;
            logic       wr;
            pv = ($urandom_range(0, 15) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
            cs = ($urandom_range(0, 15) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
            wr = 1'($urandom_range(0, 1));
            req(wr, pv, cs, (cs == 2'b00) ? pick_sel() : $urandom,
                ($urandom_range(0, 2) == 0) ? 6'($urandom) : 6'h3F,
                "R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 random");
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end
        @(negedge clk);
        check({trap_kind, rsp_valid} == {3'b001, 1'b0}, "R10 idle trap none",
              100'({trap_kind, rsp_valid}), 100'(4'b0010));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule